// File: doc/BRIEF.md
# Parallel-Compare Inversion Noise Sampler

This block converts a stream of 16-bit uniform random words into signed noise samples drawn from a discrete, zero-centred, approximately Gaussian distribution. The conversion uses inversion sampling against a cumulative table. Fifteen bits of each word form an unsigned draw. The draw is compared with every table entry in the same cycle. The number of entries lying strictly below the draw is the sample magnitude. The remaining bit of the word chooses the sign. The signed result is given as a residue modulo a power-of-two modulus, so a lattice multiply-accumulate core can add it directly as an error term.

Every comparator is evaluated for every word and no early exit exists. Latency and switching activity therefore do not depend on the value drawn. One register stage sits between the random-word handshake and the sample handshake. While the consumer accepts, the block takes one word and delivers one sample per clock. When the consumer stalls, the held sample stays frozen and the input is refused. A parameter selects one of two cumulative tables: a 12-entry table (the default, magnitudes 0 to 11) or an 11-entry table (magnitudes 0 to 10). A second parameter sets the width of the modulus.

Top module: `cdf_noise_sampler`

## Requirements
- R1: With the default table {4727, 13584, 20864, 26113, 29434, 31278, 32176, 32560, 32704, 32751, 32764, 32767}, the magnitude for a draw y is the smallest index i such that y <= D[i], which equals the number of entries strictly less than y.
- R2: The draw y is bits [15:1] of `rnd_word` (range 0 to 32767) and bit 0 is the sign. When bit 0 is 0, `smp_value` equals the magnitude, zero-extended.
- R3: When bit 0 is 1, `smp_value` equals (2^Q_BITS − magnitude) mod 2^Q_BITS. A zero magnitude with the sign bit set gives 0.
- R4: The magnitude never exceeds the table length minus one: 11 with the default table and 10 with the alternate table.
- R5: A word accepted at a clock edge (`rnd_valid` and `rnd_ready` both high) produces its sample on `smp_value` with `smp_valid` high right after that same edge, for every input value.
- R6: While `smp_valid` is high and `smp_ready` is low, `smp_valid` stays high, `smp_value` stays unchanged and `rnd_ready` is low.
- R7: `rnd_ready` is high whenever the output register is empty or is being consumed in the current cycle. With `smp_ready` held high, one word is accepted on every clock.
- R8: In the cycle after a clock edge with `rst` high, `smp_valid` is low.
- R9: With TABLE_SEL = 1, the table is the cumulative form of the weights {11278, 10277, 7774, 4882, 2545, 1101, 396, 118, 29, 6, 1}. Its first entry is half the central weight minus one, and each later entry adds the next weight, giving {5638, 15915, 23689, 28571, 31116, 32217, 32613, 32731, 32760, 32766, 32767}. R1 to R3 apply to this table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rnd_valid | input | 1 | Random word is present |
| rnd_ready | output | 1 | Block can accept a random word |
| rnd_word | input | Y_W+1 (16) | Bits [15:1] are the draw y, bit 0 is the sign |
| smp_valid | output | 1 | Sample register holds a result |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_value | output | Q_BITS (15) | Signed sample as a residue modulo 2^Q_BITS |

## Verification
The bench builds two copies side by side and drives both with the same input. The first uses the defaults (12-entry table, 15-bit modulus). The second uses TABLE_SEL = 1 with a 16-bit modulus. All 65536 input words stream through both copies back to back, so every draw is tested with both signs against both tables, including every boundary where y equals a table entry or is one past it. A short stall sequence then drives the largest negative sample and the negative-zero case under backpressure.

// File: rtl/noise_pkg.sv
package noise_pkg;

  localparam int MAX_ENTRIES = 12;

  // Probability weights (units of 2^-15) of |x| = k; k = 0 is the centre.
  function automatic int pdf_weight(input int sel, input int k);
    int w;
    w = 0;
    if (sel == 1) begin
      case (k)
        0: w = 11278;  1: w = 10277;  2: w = 7774;  3: w = 4882;
        4: w = 2545;   5: w = 1101;   6: w = 396;   7: w = 118;
        8: w = 29;     9: w = 6;      10: w = 1;
        default: w = 0;
      endcase
    end else begin
      case (k)
        0: w = 9456;   1: w = 8857;   2: w = 7280;  3: w = 5249;
        4: w = 3321;   5: w = 1844;   6: w = 898;   7: w = 384;
        8: w = 144;    9: w = 47;     10: w = 13;   11: w = 3;
        default: w = 0;
      endcase
    end
    return w;
  endfunction

  function automatic int table_len(input int sel);
    return (sel == 1) ? 11 : 12;
  endfunction

  // Cumulative bound: half the centre weight minus one, then running sum.
  function automatic int cdf_entry(input int sel, input int idx);
    int acc;
    acc = pdf_weight(sel, 0) / 2 - 1;
    for (int k = 1; k < MAX_ENTRIES; k++) begin
      if (k <= idx) acc = acc + pdf_weight(sel, k);
    end
    return acc;
  endfunction

endpackage

// File: rtl/cdf_compare.sv
module cdf_compare #(
  parameter int TABLE_SEL = 0,
  parameter int N         = 12,
  parameter int Y_W       = 15
) (
  input  logic [Y_W-1:0] y,
  output logic [N-1:0]   above
);
  // One comparator per entry, all evaluated every cycle.
  for (genvar i = 0; i < N; i++) begin : g_cmp
    localparam logic [Y_W-1:0] BOUND = Y_W'(noise_pkg::cdf_entry(TABLE_SEL, i));
    assign above[i] = (y > BOUND);
  end
endmodule

// File: rtl/cdf_popcount.sv
module cdf_popcount #(
  parameter int N     = 12,
  parameter int MAG_W = 4
) (
  input  logic [N-1:0]     above,
  output logic [MAG_W-1:0] mag
);
  always_comb begin
    mag = '0;
    for (int i = 0; i < N; i++) begin
      mag = mag + MAG_W'(above[i]);
    end
  end
endmodule

// File: rtl/sign_fold.sv
module sign_fold #(
  parameter int MAG_W  = 4,
  parameter int Q_BITS = 15
) (
  input  logic [MAG_W-1:0]  mag,
  input  logic              neg,
  output logic [Q_BITS-1:0] val
);
  logic [Q_BITS-1:0] ext;
  assign ext = Q_BITS'(mag);
  assign val = neg ? (Q_BITS'(0) - ext) : ext;
endmodule

// File: rtl/cdf_noise_sampler.sv
module cdf_noise_sampler #(
  parameter int TABLE_SEL = 0,
  parameter int Q_BITS    = 15,
  parameter int Y_W       = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rnd_valid,
  output logic              rnd_ready,
  input  logic [Y_W:0]      rnd_word,
  output logic              smp_valid,
  input  logic              smp_ready,
  output logic [Q_BITS-1:0] smp_value
);
  localparam int N     = noise_pkg::table_len(TABLE_SEL);
  localparam int MAG_W = $clog2(N);

  logic [N-1:0]      above;
  logic [MAG_W-1:0]  mag_w;
  logic [Q_BITS-1:0] folded;
  logic              take;

  cdf_compare #(.TABLE_SEL(TABLE_SEL), .N(N), .Y_W(Y_W)) u_cmp (
    .y(rnd_word[Y_W:1]), .above(above)
  );

  cdf_popcount #(.N(N), .MAG_W(MAG_W)) u_cnt (
    .above(above), .mag(mag_w)
  );

  sign_fold #(.MAG_W(MAG_W), .Q_BITS(Q_BITS)) u_fold (
    .mag(mag_w), .neg(rnd_word[0]), .val(folded)
  );

  assign rnd_ready = !smp_valid || smp_ready;
  assign take      = rnd_valid && rnd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_valid <= 1'b0;
      smp_value <= '0;
    end else if (take) begin
      smp_valid <= 1'b1;
      smp_value <= folded;
    end else if (smp_ready) begin
      smp_valid <= 1'b0;
    end
  end

  assert_mag_range_R4: assert property (@(posedge clk) disable iff (rst)
    rnd_valid |-> (mag_w <= MAG_W'(N - 1)));

  assert_accept_latency_R5: assert property (@(posedge clk) disable iff (rst)
    take |=> smp_valid);

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_value)));

  assert_ready_when_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |-> rnd_ready);

  assert_neg_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (take && mag_w == '0) |=> (smp_value == '0));

  assert_reset_empty_R8: assert property (@(posedge clk)
    rst |=> !smp_valid);

endmodule

// File: tb/cdf_noise_sampler_test.sv
module cdf_noise_sampler_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rnd_valid = 1'b0;
  logic [15:0] rnd_word = '0;
  logic        smp_ready = 1'b0;
  logic        rnd_ready, smp_valid, rnd_ready_b, smp_valid_b;
  logic [14:0] smp_value;
  logic [15:0] smp_value_b;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdf_noise_sampler uut (
    .clk(clk), .rst(rst), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready),
    .rnd_word(rnd_word), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_value(smp_value)
  );

  cdf_noise_sampler #(.TABLE_SEL(1), .Q_BITS(16)) uut_alt (
    .clk(clk), .rst(rst), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready_b),
    .rnd_word(rnd_word), .smp_valid(smp_valid_b), .smp_ready(smp_ready),
    .smp_value(smp_value_b)
  );

  int tbl_a[12] = '{4727, 13584, 20864, 26113, 29434, 31278, 32176, 32560,
                    32704, 32751, 32764, 32767};
  int wts_b[11] = '{11278, 10277, 7774, 4882, 2545, 1101, 396, 118, 29, 6, 1};
  int tbl_b[11];

  function automatic int ref_mag(input bit alt, input int y);
    int n;
    n = alt ? 11 : 12;
    for (int i = 0; i < n; i++) begin
      if (y <= (alt ? tbl_b[i] : tbl_a[i])) return i;
    end
    return n;
  endfunction

  function automatic int ref_val(input bit alt, input int w);
    int m, modq;
    m = ref_mag(alt, w >> 1);
    modq = alt ? 65536 : 32768;
    if ((w & 1) != 0) return (modq - m) % modq;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    tbl_b[0] = wts_b[0] / 2 - 1;
    for (int i = 1; i < 11; i++) tbl_b[i] = tbl_b[i-1] + wts_b[i];

    repeat (3) @(negedge clk);
    check(smp_valid == 1'b0, "R8", int'(smp_valid), 0);
    check(smp_valid_b == 1'b0, "R8", int'(smp_valid_b), 0);
    rst = 1'b0;
    @(negedge clk);
    check(rnd_ready == 1'b1, "R7", int'(rnd_ready), 1);

    // Exhaustive stream: both tables, every draw, both signs.
    smp_ready = 1'b1;
    rnd_valid = 1'b1;
    for (int w = 0; w < 65536; w++) begin
      int ea, eb;
      rnd_word = 16'(w);
      @(negedge clk);
      ea = ref_val(0, w);
      eb = ref_val(1, w);
      check(smp_valid == 1'b1, "R5", int'(smp_valid), 1);
      check(rnd_ready == 1'b1, "R7", int'(rnd_ready), 1);
      if ((w & 1) == 0) begin
        check(int'(smp_value) == ea, "R1 R2", int'(smp_value), ea);
        check(int'(smp_value_b) == eb, "R9 R2", int'(smp_value_b), eb);
        check(int'(smp_value) <= 11, "R4", int'(smp_value), 11);
        check(int'(smp_value_b) <= 10, "R4", int'(smp_value_b), 10);
      end else begin
        check(int'(smp_value) == ea, "R3", int'(smp_value), ea);
        check(int'(smp_value_b) == eb, "R9 R3", int'(smp_value_b), eb);
      end
    end

    // Backpressure: largest negative sample held, then negative zero.
    rnd_word = 16'hFFFF;
    smp_ready = 1'b0;
    @(negedge clk);
    check(int'(smp_value) == 32768 - 11, "R3", int'(smp_value), 32757);
    check(int'(smp_value_b) == 65536 - 10, "R9", int'(smp_value_b), 65526);
    rnd_word = 16'h0001;
    check(rnd_ready == 1'b0, "R6", int'(rnd_ready), 0);
    @(negedge clk);
    check(smp_valid == 1'b1, "R6", int'(smp_valid), 1);
    check(int'(smp_value) == 32757, "R6", int'(smp_value), 32757);
    smp_ready = 1'b1;
    @(negedge clk);
    check(int'(smp_value) == 0, "R3", int'(smp_value), 0);
    check(smp_valid == 1'b1, "R5", int'(smp_valid), 1);
    rnd_valid = 1'b0;
    @(negedge clk);
    check(smp_valid == 1'b0, "R7", int'(smp_valid), 0);

    rst = 1'b1;
    @(negedge clk);
    check(smp_valid == 1'b0, "R8", int'(smp_valid), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule